// File: doc/BRIEF.md
# Flash depletion-recovery pulse sequencer

This block recovers over-erased flash cells without help from software. After `start_i` it runs a loop. At the top of every pass it asks the array for a depletion check, which is a read in inverse-erase mode, and waits for the result. If no cell is still depleted, the loop ends with `done_o`.

When depleted cells remain, the block first confirms that the programming supply is at core level. It then drives a write port into the array's control register through a fixed sequence:

1. Select write mode on every segment.
2. Wait the mode-settle time.
3. Fire the pulse with one keyed write that also keeps the mode and segment bits.
4. Wait the pulse width.
5. Clear the whole register.
6. Wait the deselect time before the next check.

The three waits are cycle counts supplied at the ports. A programmable budget of pulses bounds the loop. If the budget is spent and cells are still depleted, the block raises `fail_o` instead of `done_o`. If the supply is low when a pulse is due, it raises `supply_err_o` instead.

Top module: `fdr_seq`

## Requirements
- R1: After reset the block is idle. `busy_o`, `reg_we_o`, `chk_req_o`, `done_o`, `fail_o` and `supply_err_o` are all low.
- R2: A depleted result, with budget left but `vccp_ok_i` low, gives a one-cycle `supply_err_o` one cycle after the result. No register write occurs and the block goes idle.
- R3: After `start_i` the block holds `chk_req_o` high until `chk_valid_i`. A result that is not depleted (`chk_depleted_i`=0) gives a one-cycle `done_o` one cycle after the result, with no register write. At most one of `done_o`, `fail_o` and `supply_err_o` is high in any cycle.
- R4: A depleted result that leads to a pulse writes the mode word one cycle after the result. The mode word is 16'hFF04: bits [15:8] are the eight segment enables, all set, and bits [2:1] hold the write-mode code 2'b10.
- R5: The pulse write comes exactly max(`mode_cyc_i`,1) cycles after the mode write. It is 16'hFF15: execute bit [0]=1, key bit [4]=1 and key bit [3]=0, all in that one write, with bits [15:8] and [2:1] unchanged from the mode word.
- R6: The clearing write 16'h0000 comes exactly max(`pulse_cyc_i`,1) cycles after the pulse write.
- R7: `chk_req_o` rises again exactly max(`busy_cyc_i`,1) cycles after the clearing write, which starts the next pass.
- R8: A wait count of zero behaves as a one-cycle wait.
- R9: A depleted result after `max_iter_i` pulses in this run gives a one-cycle `fail_o` one cycle after the result. This includes the case `max_iter_i`=0.
- R10: `start_i` while `busy_o` is high is ignored. The run's write timing and pulse count are unchanged.
- R11: `abort_i` in any state causes a write of 16'h0000 in the next cycle, with `busy_o` low. No further writes occur until a new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a recovery run (ignored while busy) |
| abort_i | input | 1 | Clear the register and return to idle |
| vccp_ok_i | input | 1 | Programming supply is at core level |
| mode_cyc_i | input | CW | Mode-settle wait in cycles |
| pulse_cyc_i | input | CW | Pulse-width wait in cycles |
| busy_cyc_i | input | CW | Deselect wait in cycles |
| max_iter_i | input | IW | Pulse budget for one run |
| chk_req_o | output | 1 | Depletion check (inverse-erase read) requested |
| chk_valid_i | input | 1 | Depletion check result valid |
| chk_depleted_i | input | 1 | Check found cells still depleted |
| reg_we_o | output | 1 | Control register write strobe |
| reg_wdata_o | output | 16 | Control register write data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse: run ended clean |
| fail_o | output | 1 | One-cycle pulse: budget spent, still depleted |
| supply_err_o | output | 1 | One-cycle pulse: pulse refused, supply low |

## Verification
The bench measures every result as a cycle distance from the event that causes it:

| Result | Due |
|--------|-----|
| Mode word | 1 cycle after the accepted check result |
| Any outcome pulse | 1 cycle after the accepted check result |
| Pulse word | max(mode,1) cycles after the mode word |
| Clearing word | max(pulse,1) cycles after the pulse word |
| Next check request | max(busy,1) cycles after the clearing word |
| Zero write after an abort | the cycle after the abort |

A monitor samples on the falling edge. It records the cycle number of each check result and each write, then compares the differences with the expected waits. The bench computes those waits from the programmed counts, clamping zero to one.

A sweep covers the wait counts, the number of passes needed and the budget. The expected outcome and pulse count come from min(passes, budget) and from the supply level.

// File: rtl/fdr_pkg.sv
package fdr_pkg;
   localparam int unsigned FDR_WORD_W    = 16;
   localparam int unsigned FDR_SEG_MAX   = 8;
   localparam int unsigned FDR_SEG_LSB   = 8;
   localparam int unsigned FDR_EXE_POS   = 0;
   localparam int unsigned FDR_MODE_LSB  = 1;
   localparam int unsigned FDR_KEY0_POS  = 3;
   localparam int unsigned FDR_KEY1_POS  = 4;
   localparam logic [1:0]  FDR_MODE_WRITE = 2'b10;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_MODE,
      ST_PULSE,
      ST_BUSY
   } fdr_state_e;

   typedef enum logic [1:0] {
      WSEL_CLEAR,
      WSEL_MODE,
      WSEL_PULSE
   } fdr_wsel_e;

   typedef enum logic [1:0] {
      TSEL_MODE,
      TSEL_PULSE,
      TSEL_BUSY
   } fdr_tsel_e;
endpackage

// File: rtl/fdr_word.sv
module fdr_word
   import fdr_pkg::*;
#(
   parameter int unsigned NUM_SEG = 8
) (
   input  fdr_wsel_e                sel_i,
   output logic [FDR_WORD_W-1:0]    word_o
);
   localparam int unsigned SEG_W = FDR_SEG_MAX;

   logic [SEG_W-1:0] seg;
   logic             seg_on;

   assign seg_on = (sel_i != WSEL_CLEAR);

   generate
      if (NUM_SEG < 1 || NUM_SEG > SEG_W) begin : g_bad_seg
         $error("fdr_word: NUM_SEG out of range");
      end
      for (genvar g = 0; g < SEG_W; g++) begin : g_seg
         if (g < NUM_SEG) begin : g_on
            assign seg[g] = seg_on;
         end else begin : g_off
            assign seg[g] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      word_o = '0;
      word_o[FDR_SEG_LSB +: SEG_W] = seg;
      if (seg_on) begin
         word_o[FDR_MODE_LSB +: 2] = FDR_MODE_WRITE;
      end
      if (sel_i == WSEL_PULSE) begin
         word_o[FDR_EXE_POS]  = 1'b1;
         word_o[FDR_KEY1_POS] = 1'b1;
         word_o[FDR_KEY0_POS] = 1'b0;
      end
   end
endmodule

// File: rtl/fdr_delay.sv
module fdr_delay #(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] val_i,
   output logic          expire_o
);
   localparam logic [CW-1:0] ONE = 1;

   logic [CW-1:0] cnt;

   generate
      if (CW < 2) begin : g_bad_cw
         $error("fdr_delay: CW must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load_i) begin
         cnt <= (val_i == '0) ? ONE : val_i;
      end else if (cnt != '0) begin
         cnt <= cnt - ONE;
      end
   end

   assign expire_o = (cnt == ONE);

   // R8: a zero count still waits exactly one cycle
   a_r8_zero_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      load_i && (val_i == '0) |=> expire_o);

   a_r8_count_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      load_i && (val_i != '0) |=> cnt == $past(val_i));
endmodule

// File: rtl/fdr_iter.sv
module fdr_iter #(
   parameter int unsigned IW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          inc_i,
   input  logic [IW-1:0] max_i,
   output logic          at_limit_o
);
   localparam logic [IW-1:0] ONE = 1;

   logic [IW-1:0] cnt;

   generate
      if (IW < 1) begin : g_bad_iw
         $error("fdr_iter: IW must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr_i) begin
         cnt <= '0;
      end else if (inc_i) begin
         cnt <= cnt + ONE;
      end
   end

   assign at_limit_o = (cnt >= max_i);

   // R9: a pulse is never granted once the budget is spent
   a_r9_budget_respected: assert property (@(posedge clk) disable iff (!rst_n)
      inc_i && !clr_i |-> !at_limit_o);
endmodule

// File: rtl/fdr_seq.sv
module fdr_seq
   import fdr_pkg::*;
#(
   parameter int unsigned CW      = 16,
   parameter int unsigned IW      = 8,
   parameter int unsigned NUM_SEG = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic                  abort_i,
   input  logic                  vccp_ok_i,
   input  logic [CW-1:0]         mode_cyc_i,
   input  logic [CW-1:0]         pulse_cyc_i,
   input  logic [CW-1:0]         busy_cyc_i,
   input  logic [IW-1:0]         max_iter_i,
   output logic                  chk_req_o,
   input  logic                  chk_valid_i,
   input  logic                  chk_depleted_i,
   output logic                  reg_we_o,
   output logic [FDR_WORD_W-1:0] reg_wdata_o,
   output logic                  busy_o,
   output logic                  done_o,
   output logic                  fail_o,
   output logic                  supply_err_o
);
   localparam int unsigned WW = FDR_WORD_W;

   fdr_state_e    st, st_nxt;
   fdr_wsel_e     wsel;
   fdr_tsel_e     tsel;
   logic          we_d, done_d, fail_d, err_d;
   logic          t_load, t_exp;
   logic [CW-1:0] t_val;
   logic          it_clr, it_inc, it_lim;
   logic [WW-1:0] word;

   fdr_word #(.NUM_SEG(NUM_SEG)) i_word (
      .sel_i  (wsel),
      .word_o (word)
   );

   fdr_delay #(.CW(CW)) i_delay (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (t_load),
      .val_i    (t_val),
      .expire_o (t_exp)
   );

   fdr_iter #(.IW(IW)) i_iter (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (it_clr),
      .inc_i      (it_inc),
      .max_i      (max_iter_i),
      .at_limit_o (it_lim)
   );

   always_comb begin
      case (tsel)
         TSEL_PULSE: t_val = pulse_cyc_i;
         TSEL_BUSY:  t_val = busy_cyc_i;
         default:    t_val = mode_cyc_i;
      endcase
   end

   always_comb begin
      st_nxt = st;
      we_d   = 1'b0;
      wsel   = WSEL_CLEAR;
      tsel   = TSEL_MODE;
      t_load = 1'b0;
      it_clr = 1'b0;
      it_inc = 1'b0;
      done_d = 1'b0;
      fail_d = 1'b0;
      err_d  = 1'b0;
      if (abort_i) begin
         st_nxt = ST_IDLE;
         we_d   = 1'b1;
      end else begin
         case (st)
            ST_IDLE: begin
               if (start_i) begin
                  st_nxt = ST_CHECK;
                  it_clr = 1'b1;
               end
            end
            ST_CHECK: begin
               if (chk_valid_i) begin
                  if (!chk_depleted_i) begin
                     done_d = 1'b1;
                     st_nxt = ST_IDLE;
                  end else if (it_lim) begin
                     fail_d = 1'b1;
                     st_nxt = ST_IDLE;
                  end else if (!vccp_ok_i) begin
                     err_d  = 1'b1;
                     st_nxt = ST_IDLE;
                  end else begin
                     we_d   = 1'b1;
                     wsel   = WSEL_MODE;
                     tsel   = TSEL_MODE;
                     t_load = 1'b1;
                     it_inc = 1'b1;
                     st_nxt = ST_MODE;
                  end
               end
            end
            ST_MODE: begin
               if (t_exp) begin
                  we_d   = 1'b1;
                  wsel   = WSEL_PULSE;
                  tsel   = TSEL_PULSE;
                  t_load = 1'b1;
                  st_nxt = ST_PULSE;
               end
            end
            ST_PULSE: begin
               if (t_exp) begin
                  we_d   = 1'b1;
                  wsel   = WSEL_CLEAR;
                  tsel   = TSEL_BUSY;
                  t_load = 1'b1;
                  st_nxt = ST_BUSY;
               end
            end
            ST_BUSY: begin
               if (t_exp) begin
                  st_nxt = ST_CHECK;
               end
            end
            default: st_nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         reg_we_o     <= 1'b0;
         reg_wdata_o  <= '0;
         done_o       <= 1'b0;
         fail_o       <= 1'b0;
         supply_err_o <= 1'b0;
      end else begin
         st           <= st_nxt;
         reg_we_o     <= we_d;
         reg_wdata_o  <= we_d ? word : '0;
         done_o       <= done_d;
         fail_o       <= fail_d;
         supply_err_o <= err_d;
      end
   end

   assign busy_o    = (st != ST_IDLE);
   assign chk_req_o = (st == ST_CHECK);

   // R5: the keyed execute write carries keys, mode and segments together
   a_r5_keyed_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we_o && reg_wdata_o[FDR_EXE_POS] |->
         reg_wdata_o[FDR_KEY1_POS] && !reg_wdata_o[FDR_KEY0_POS] &&
         (reg_wdata_o[FDR_MODE_LSB +: 2] == FDR_MODE_WRITE) &&
         (reg_wdata_o[FDR_SEG_LSB +: NUM_SEG] == {NUM_SEG{1'b1}}));

   // R6: the cycle after a pulse write carries no write or a clearing write
   a_r6_pulse_then_clear: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we_o && reg_wdata_o[FDR_EXE_POS] |=> !reg_we_o || (reg_wdata_o == '0));

   // R2: a mode write only follows a cycle with the supply good
   a_r2_supply_before_mode: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we_o && reg_wdata_o[FDR_MODE_LSB +: 2] == FDR_MODE_WRITE &&
      !reg_wdata_o[FDR_EXE_POS] |-> $past(vccp_ok_i));

   // R3: the check request is held until a result arrives
   a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      chk_req_o && !chk_valid_i && !abort_i |=> chk_req_o);

   a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, fail_o, supply_err_o}));

   // R11: abort clears the register and idles the block next cycle
   a_r11_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> reg_we_o && (reg_wdata_o == '0) && !busy_o);
endmodule

// File: tb/test_fdr_seq.sv
`timescale 1ns/1ps
module test_fdr_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, abort_i = 1'b0, vccp_ok_i = 1'b1;
   logic [15:0] mode_cyc_i = '0, pulse_cyc_i = '0, busy_cyc_i = '0;
   logic [7:0]  max_iter_i = '0;
   logic        chk_req_o, chk_valid_i = 1'b0, chk_depleted_i = 1'b0;
   logic        reg_we_o, busy_o, done_o, fail_o, supply_err_o;
   logic [15:0] reg_wdata_o;

   fdr_seq i_fdr_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
      .vccp_ok_i(vccp_ok_i), .mode_cyc_i(mode_cyc_i), .pulse_cyc_i(pulse_cyc_i),
      .busy_cyc_i(busy_cyc_i), .max_iter_i(max_iter_i), .chk_req_o(chk_req_o),
      .chk_valid_i(chk_valid_i), .chk_depleted_i(chk_depleted_i),
      .reg_we_o(reg_we_o), .reg_wdata_o(reg_wdata_o), .busy_o(busy_o),
      .done_o(done_o), .fail_o(fail_o), .supply_err_o(supply_err_o)
   );

   always #2.5 clk = ~clk;

   int  n_chk = 0, n_bad = 0;
   int  cyc = 0;
   int  res_cyc = 0, mode_at = 0, pulse_at = 0, clr_at = 0;
   int  pulses = 0, outcome = 0, depl = 0, lat = 0;
   int  e_m = 1, e_p = 1, e_b = 1;
   bit  mon_en = 1'b1, prev_req = 1'b0, finished = 1'b0;
   localparam int LAT = 2;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // Monitor and flash model, both on the falling edge.
   always @(negedge clk) begin
      if (mon_en && rst_n) begin
         if (reg_we_o) begin
            if (reg_wdata_o == 16'hFF04) begin
               chk(cyc == res_cyc + 1, "R4 mode word timing", cyc, res_cyc + 1);
               mode_at = cyc;
            end else if (reg_wdata_o == 16'hFF15) begin
               chk(cyc == mode_at + e_m, "R5 pulse word timing", cyc - mode_at, e_m);
               pulse_at = cyc;
               pulses++;
               if (depl > 0) depl--;
            end else if (reg_wdata_o == 16'h0000) begin
               chk(cyc == pulse_at + e_p, "R6 clear word timing", cyc - pulse_at, e_p);
               clr_at = cyc;
            end else begin
               chk(1'b0, "R4 unexpected write word", reg_wdata_o, 16'hFF04);
            end
         end
         if (chk_req_o && !prev_req && pulses > 0)
            chk(cyc == clr_at + e_b, "R7 next check timing", cyc - clr_at, e_b);
         if (done_o || fail_o || supply_err_o) begin
            outcome = done_o ? 1 : (fail_o ? 2 : 3);
            chk(cyc == res_cyc + 1, "R3 outcome timing", cyc, res_cyc + 1);
         end
      end
      prev_req = chk_req_o;
      if (chk_valid_i) begin
         chk_valid_i = 1'b0;
         lat = 0;
      end else if (chk_req_o) begin
         if (lat >= LAT) begin
            chk_valid_i    = 1'b1;
            chk_depleted_i = (depl > 0);
            res_cyc        = cyc;
            lat            = 0;
         end else begin
            lat++;
         end
      end else begin
         lat = 0;
      end
   end

   task automatic run_case(input int m, input int p, input int b, input int d,
                           input int mx, input bit vok, input bit poke);
      int exp_o, exp_p;
      bit poked;
      poked = 1'b0;
      @(negedge clk);
      mode_cyc_i = 16'(m); pulse_cyc_i = 16'(p); busy_cyc_i = 16'(b);
      max_iter_i = 8'(mx); vccp_ok_i = vok; depl = d;
      e_m = (m == 0) ? 1 : m; e_p = (p == 0) ? 1 : p; e_b = (b == 0) ? 1 : b;
      pulses = 0; outcome = 0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 3000 && outcome == 0; i++) begin
         @(posedge clk);
         if (poke && !poked && pulses == 1) begin
            @(negedge clk); start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
            poked = 1'b1;
         end
      end
      if (d == 0) begin exp_o = 1; exp_p = 0; end
      else if (mx == 0) begin exp_o = 2; exp_p = 0; end
      else if (!vok) begin exp_o = 3; exp_p = 0; end
      else if (d <= mx) begin exp_o = 1; exp_p = d; end
      else begin exp_o = 2; exp_p = mx; end
      if (exp_o == 3) chk(outcome == exp_o, "R2 supply refusal outcome", outcome, exp_o);
      else if (exp_o == 2) chk(outcome == exp_o, "R9 budget fail outcome", outcome, exp_o);
      else chk(outcome == exp_o, "R3 done outcome", outcome, exp_o);
      if (poke) chk(pulses == exp_p, "R10 start while busy ignored", pulses, exp_p);
      else chk(pulses == exp_p, "R7 pulse count per run", pulses, exp_p);
      repeat (2) @(negedge clk);
      chk(!busy_o, "R3 idle after outcome", busy_o, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int mv[3] = '{0, 1, 3};
      int pv[2] = '{0, 2};
      int xv[3] = '{0, 2, 3};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o && !reg_we_o && !chk_req_o, "R1 reset idle", {busy_o, reg_we_o, chk_req_o}, 0);
      chk(!done_o && !fail_o && !supply_err_o, "R1 reset outcomes low",
          {done_o, fail_o, supply_err_o}, 0);

      // R8 zero counts appear throughout the sweep
      for (int a = 0; a < 3; a++)
         for (int c = 0; c < 2; c++)
            for (int e = 0; e < 3; e++)
               for (int d = 0; d < 4; d++)
                  for (int x = 0; x < 3; x++)
                     run_case(mv[a], pv[c], mv[e], d, xv[x], 1'b1, 1'b0);

      // R2 supply low
      for (int d = 0; d < 3; d++)
         for (int x = 0; x < 3; x++)
            run_case(1, 1, 1, d, x, 1'b0, 1'b0);

      // R10 start pulsed mid-run
      run_case(2, 2, 2, 2, 3, 1'b1, 1'b1);
      run_case(0, 3, 1, 3, 3, 1'b1, 1'b1);

      // R11 abort during the pulse
      mon_en = 1'b0;
      @(negedge clk);
      mode_cyc_i = 16'd3; pulse_cyc_i = 16'd4; busy_cyc_i = 16'd2;
      max_iter_i = 8'd5; vccp_ok_i = 1'b1; depl = 5;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 500; i++) begin
         if (reg_we_o && reg_wdata_o == 16'hFF15) break;
         @(negedge clk);
      end
      abort_i = 1'b1;
      @(negedge clk);
      abort_i = 1'b0;
      chk(reg_we_o && reg_wdata_o == 16'h0000, "R11 abort clearing write",
          {reg_we_o, reg_wdata_o}, {1'b1, 16'h0000});
      chk(!busy_o, "R11 abort returns idle", busy_o, 0);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         chk(!reg_we_o && !chk_req_o && !busy_o, "R11 quiet after abort",
             {reg_we_o, chk_req_o, busy_o}, 0);
      end
      mon_en = 1'b1;
      run_case(1, 1, 1, 1, 2, 1'b1, 1'b0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule